// File: doc/BRIEF.md
# Translation Mode and Quadrant Decoder

This block is the first stage of a 64-bit radix address translation unit. Each request carries an effective address, an access kind (load, store or instruction fetch) and three machine state bits: instruction relocation, data relocation and hypervisor state. From these the block decides whether the access bypasses translation (real mode) or must be translated (virtual mode).

In real mode the block produces the real address itself. It clears the top address nibble and, for hypervisor accesses in the lower half of the address space, merges in a real-mode offset register. In virtual mode the two top address bits select a quadrant. The legal quadrants give the partition and process identifiers that are handed to the table walker together with the address, with the quadrant bits cleared. The two illegal quadrants produce a segment fault, which is tagged instruction-side or data-side. A data-side fault also captures the faulting address.

Only one request is handled at a time. An accepted request yields exactly one registered result pulse on the next cycle, and the block refuses new work during that cycle.

Top module: `xlat_mode_quad`

## Requirements
- R1: Access kind encoding is 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 is handled as a load. A fetch is real mode exactly when `msr_ir` is 0. Any other kind is real mode exactly when `msr_dr` is 0.
- R2: A real-mode access raises `real_done` and drives `real_addr` with the effective address whose four most significant bits are cleared.
- R3: In real mode, when `msr_hv` is 1 and effective address bit 63 is 0, `off_reg` is ORed into `real_addr`. When `msr_hv` is 0 or bit 63 is 1, it is not ORed in.
- R4: A virtual-mode access with EA[63:62]=2'b00 raises `walk_go` with `walk_lpid` equal to `lpid_reg` and `walk_pid` equal to `pid_reg`.
- R5: A virtual-mode access with EA[63:62]=2'b11 raises `walk_go` with `walk_lpid` equal to `lpid_reg` and `walk_pid` equal to zero.
- R6: A virtual-mode access with EA[63:62] equal to 2'b01 or 2'b10 raises `fault_valid` and does not raise `walk_go`.
- R7: The fault code is 2'b01 for a fetch (instruction segment fault) and 2'b10 for any data access (data segment fault). A data segment fault loads the full 64-bit effective address into `dar`.
- R8: `dar` keeps its value on instruction segment faults and on every request that does not fault.
- R9: `walk_ea` is the effective address with bits 63:62 cleared.
- R10: A request accepted at a rising edge (`req_valid` and `req_ready` both high) gives exactly one of `real_done`, `walk_go` or `fault_valid` in the following cycle. That flag is high for that single cycle.
- R11: `req_ready` is low in the cycle a result is presented and high otherwise. A request offered while `req_ready` is low is ignored.
- R12: During and after reset, no result flag is high, `dar` is zero, `req_ready` is high, and the address, identifier and code outputs read zero whenever no result flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 load) |
| msr_ir | input | 1 | Instruction relocation enable |
| msr_dr | input | 1 | Data relocation enable |
| msr_hv | input | 1 | Hypervisor state |
| lpid_reg | input | 12 | Current partition identifier |
| pid_reg | input | 20 | Current process identifier |
| off_reg | input | 64 | Real-mode offset register |
| real_done | output | 1 | Real-mode result valid |
| real_addr | output | 64 | Real address |
| walk_go | output | 1 | Start table walk |
| walk_lpid | output | 12 | Effective partition identifier |
| walk_pid | output | 20 | Effective process identifier |
| walk_ea | output | 64 | Address for walker, quadrant bits cleared |
| fault_valid | output | 1 | Segment fault result |
| fault_code | output | 2 | 01 instruction segment, 10 data segment |
| dar | output | 64 | Captured data fault address |

## Verification
The assertions assume that the requester follows the valid/ready rule: a request counts only at an edge where both are high. They also assume that `lpid_reg`, `pid_reg` and `off_reg` are steady while the request is being accepted. The stimulus changes inputs only on falling edges. It holds each request for exactly one accepting edge and changes the identifier and offset registers only while idle. One directed case deliberately keeps `req_valid` high through a busy cycle, which drives the refusal path without breaking the handshake assumption.

// File: rtl/xlat_mode_pkg.sv
package xlat_mode_pkg;
   typedef enum logic [1:0] {
      KIND_LOAD  = 2'b00,
      KIND_STORE = 2'b01,
      KIND_FETCH = 2'b10,
      KIND_RSVD  = 2'b11
   } kind_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'b00,
      FLT_ISEG = 2'b01,
      FLT_DSEG = 2'b10
   } flt_e;

   typedef enum logic [1:0] {
      QD_APP  = 2'b00,
      QD_BAD1 = 2'b01,
      QD_BAD2 = 2'b10,
      QD_OS   = 2'b11
   } quad_e;
endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
   import xlat_mode_pkg::*;
(
   input  logic [1:0] kind,
   input  logic       ir,
   input  logic       dr,
   output logic       is_fetch,
   output logic       is_real
);
   always_comb begin
      is_fetch = (kind_e'(kind) == KIND_FETCH);
      // fetch follows instruction relocation, everything else data relocation
      is_real  = is_fetch ? !ir : !dr;
   end
endmodule

// File: rtl/xlat_real_map.sv
module xlat_real_map #(
   parameter int EA_W     = 64,
   parameter int CLR_BITS = 4
) (
   input  logic [EA_W-1:0] ea,
   input  logic            hv,
   input  logic [EA_W-1:0] off,
   output logic [EA_W-1:0] raddr
);
   localparam int KEEP_W = EA_W - CLR_BITS;

   logic [EA_W-1:0] trimmed;
   logic            use_off;

   always_comb begin
      trimmed = {{CLR_BITS{1'b0}}, ea[KEEP_W-1:0]};
      use_off = hv && !ea[EA_W-1];
      raddr   = use_off ? (trimmed | off) : trimmed;
   end
endmodule

// File: rtl/xlat_quad_map.sv
module xlat_quad_map
   import xlat_mode_pkg::*;
#(
   parameter int EA_W   = 64,
   parameter int LPID_W = 12,
   parameter int PID_W  = 20
) (
   input  logic [EA_W-1:0]   ea,
   input  logic [LPID_W-1:0] lpid_in,
   input  logic [PID_W-1:0]  pid_in,
   output logic              legal,
   output logic [LPID_W-1:0] lpid,
   output logic [PID_W-1:0]  pid,
   output logic [EA_W-1:0]   vea
);
   quad_e quad;

   always_comb begin
      quad  = quad_e'(ea[EA_W-1 -: 2]);
      vea   = {2'b00, ea[EA_W-3:0]};
      lpid  = lpid_in;
      pid   = '0;
      legal = 1'b0;
      unique case (quad)
         QD_APP: begin
            legal = 1'b1;
            pid   = pid_in;
         end
         QD_OS: legal = 1'b1;
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/xlat_mode_quad.sv
module xlat_mode_quad
   import xlat_mode_pkg::*;
#(
   parameter int EA_W      = 64,
   parameter int LPID_W    = 12,
   parameter int PID_W     = 20,
   parameter int CLR_BITS  = 4,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [1:0]        req_kind,
   input  logic              msr_ir,
   input  logic              msr_dr,
   input  logic              msr_hv,
   input  logic [LPID_W-1:0] lpid_reg,
   input  logic [PID_W-1:0]  pid_reg,
   input  logic [EA_W-1:0]   off_reg,
   output logic              real_done,
   output logic [EA_W-1:0]   real_addr,
   output logic              walk_go,
   output logic [LPID_W-1:0] walk_lpid,
   output logic [PID_W-1:0]  walk_pid,
   output logic [EA_W-1:0]   walk_ea,
   output logic              fault_valid,
   output logic [1:0]        fault_code,
   output logic [EA_W-1:0]   dar
);
   initial begin
      assert (EA_W >= 8) else $error("EA_W too small");
      assert (CLR_BITS >= 1 && CLR_BITS <= EA_W - 2) else $error("CLR_BITS out of range");
      assert (LPID_W >= 1 && PID_W >= 1) else $error("identifier widths must be positive");
   end

   logic              is_fetch, is_real, legal, fire, busy;
   logic [EA_W-1:0]   raddr_c, vea_c;
   logic [LPID_W-1:0] lpid_c;
   logic [PID_W-1:0]  pid_c;
   logic              dseg_c;

   xlat_mode_sel u_sel (
      .kind(req_kind), .ir(msr_ir), .dr(msr_dr),
      .is_fetch(is_fetch), .is_real(is_real)
   );

   xlat_real_map #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_real (
      .ea(req_ea), .hv(msr_hv), .off(off_reg), .raddr(raddr_c)
   );

   xlat_quad_map #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_quad (
      .ea(req_ea), .lpid_in(lpid_reg), .pid_in(pid_reg),
      .legal(legal), .lpid(lpid_c), .pid(pid_c), .vea(vea_c)
   );

   assign busy      = real_done | walk_go | fault_valid;
   assign req_ready = !busy;
   assign fire      = req_valid && req_ready;
   assign dseg_c    = fire && !is_real && !legal && !is_fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         real_done   <= 1'b0;
         walk_go     <= 1'b0;
         fault_valid <= 1'b0;
         dar         <= '0;
      end else begin
         real_done   <= fire && is_real;
         walk_go     <= fire && !is_real && legal;
         fault_valid <= fire && !is_real && !legal;
         if (dseg_c) dar <= req_ea;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               real_addr  <= '0;
               walk_lpid  <= '0;
               walk_pid   <= '0;
               walk_ea    <= '0;
               fault_code <= FLT_NONE;
            end else begin
               real_addr  <= (fire && is_real) ? raddr_c : '0;
               walk_lpid  <= (fire && !is_real && legal) ? lpid_c : '0;
               walk_pid   <= (fire && !is_real && legal) ? pid_c : '0;
               walk_ea    <= (fire && !is_real && legal) ? vea_c : '0;
               fault_code <= (fire && !is_real && !legal) ?
                             (is_fetch ? FLT_ISEG : FLT_DSEG) : FLT_NONE;
            end
         end
      end else begin : g_hold_idle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               real_addr  <= '0;
               walk_lpid  <= '0;
               walk_pid   <= '0;
               walk_ea    <= '0;
               fault_code <= FLT_NONE;
            end else if (fire) begin
               real_addr  <= raddr_c;
               walk_lpid  <= lpid_c;
               walk_pid   <= pid_c;
               walk_ea    <= vea_c;
               fault_code <= is_fetch ? FLT_ISEG : FLT_DSEG;
            end
         end
      end
   endgenerate

   assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> $countones({real_done, walk_go, fault_valid}) == 1);

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !(real_done || walk_go || fault_valid));

   assert_refuse_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> !(real_done || walk_go || fault_valid));

   assert_top_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      real_done |-> real_addr[EA_W-1 -: CLR_BITS] == '0);

   assert_walk_ea_R9: assert property (@(posedge clk) disable iff (!rst_n)
      walk_go |-> walk_ea[EA_W-1 -: 2] == 2'b00);

   assert_fault_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_code == FLT_ISEG || fault_code == FLT_DSEG));

   assert_dar_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dseg_c |=> dar == $past(req_ea));

   assert_dar_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dar) |-> (fault_valid && fault_code == FLT_DSEG));
endmodule

// File: tb/xlat_mode_quad_test.sv
module xlat_mode_quad_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, req_valid, req_ready, msr_ir, msr_dr, msr_hv;
   logic [63:0] req_ea, off_reg, real_addr, walk_ea, dar;
   logic [1:0]  req_kind, fault_code;
   logic [11:0] lpid_reg, walk_lpid;
   logic [19:0] pid_reg, walk_pid;
   logic        real_done, walk_go, fault_valid;

   xlat_mode_quad uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ea(req_ea), .req_kind(req_kind), .msr_ir(msr_ir), .msr_dr(msr_dr),
      .msr_hv(msr_hv), .lpid_reg(lpid_reg), .pid_reg(pid_reg), .off_reg(off_reg),
      .real_done(real_done), .real_addr(real_addr), .walk_go(walk_go),
      .walk_lpid(walk_lpid), .walk_pid(walk_pid), .walk_ea(walk_ea),
      .fault_valid(fault_valid), .fault_code(fault_code), .dar(dar)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   localparam logic [11:0] LPID = 12'hA5C;
   localparam logic [19:0] PID  = 20'h31234;
   localparam logic [63:0] OFF  = 64'h0000_0000_4000_0000;

   // kind of expected result: 0 real, 1 walk, 2 instruction fault, 3 data fault
   localparam int N = 13;
   localparam logic [63:0] V_EA [N] = '{
      64'hF123_4567_89AB_CDEF, 64'h7000_0000_0000_1000, 64'h8000_0000_0000_2000,
      64'h0000_0000_0000_3000, 64'h0012_3456_789A_B000, 64'hC000_0000_DEAD_0000,
      64'h4000_0000_0000_0100, 64'h8000_0000_0000_0200, 64'h4000_0000_0000_0300,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0040, 64'hC000_0000_0000_0080,
      64'h8000_0000_0000_0500};
   localparam logic [1:0] V_KIND [N] = '{2, 0, 1, 0, 0, 2, 2, 1, 3, 3, 2, 0, 2};
   // {ir, dr, hv}
   localparam logic [2:0] V_MSR [N] = '{3'b010, 3'b101, 3'b101, 3'b100, 3'b010, 3'b100,
                                        3'b100, 3'b010, 3'b010, 3'b101, 3'b100, 3'b010, 3'b110};
   localparam logic [1:0] V_RES [N] = '{0, 0, 0, 0, 1, 1, 2, 3, 3, 0, 1, 1, 2};
   localparam logic [63:0] V_EXP [N] = '{
      64'h0123_4567_89AB_CDEF, 64'h0000_0000_4000_1000, 64'h0000_0000_0000_2000,
      64'h0000_0000_0000_3000, 64'h0012_3456_789A_B000, 64'h0000_0000_DEAD_0000,
      64'h0, 64'h0, 64'h0,
      64'h0FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0040, 64'h0000_0000_0000_0080,
      64'h0};
   localparam bit V_Q3 [N] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0};
   localparam logic [63:0] V_DAR [N] = '{
      64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
      64'h8000_0000_0000_0200, 64'h4000_0000_0000_0300, 64'h4000_0000_0000_0300,
      64'h4000_0000_0000_0300, 64'h4000_0000_0000_0300, 64'h4000_0000_0000_0300};

   task automatic drive(input logic [63:0] ea, input logic [1:0] kind, input logic [2:0] msr);
      req_ea    = ea;
      req_kind  = kind;
      {msr_ir, msr_dr, msr_hv} = msr;
      req_valid = 1'b1;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 20000, 0);
      summary();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_kind = '0;
      {msr_ir, msr_dr, msr_hv} = 3'b000;
      lpid_reg = LPID; pid_reg = PID; off_reg = OFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      chk(!(real_done || walk_go || fault_valid), "R12 flags", {61'b0, real_done, walk_go, fault_valid}, 64'h0);
      chk(dar == 64'h0, "R12 dar", dar, 64'h0);
      chk(req_ready == 1'b1, "R12 ready", {63'b0, req_ready}, 64'h1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < N; i++) begin
         drive(V_EA[i], V_KIND[i], V_MSR[i]);
         @(negedge clk);
         req_valid = 1'b0;
         // R1 mode decision, R10 exactly one flag
         case (V_RES[i])
            2'd0: begin
               chk(real_done && !walk_go && !fault_valid, "R1 real", {61'b0, real_done, walk_go, fault_valid}, 64'h4);
               chk(real_addr == V_EXP[i], "R3 real_addr", real_addr, V_EXP[i]); // R2 top clear and R3 offset
            end
            2'd1: begin
               chk(walk_go && !real_done && !fault_valid, "R1 walk", {61'b0, real_done, walk_go, fault_valid}, 64'h2);
               chk(walk_ea == V_EXP[i], "R9 walk_ea", walk_ea, V_EXP[i]);
               chk(walk_lpid == LPID, "R4 lpid", {52'b0, walk_lpid}, {52'b0, LPID});
               if (V_Q3[i]) chk(walk_pid == 20'h0, "R5 pid zero", {44'b0, walk_pid}, 64'h0);
               else         chk(walk_pid == PID, "R4 pid", {44'b0, walk_pid}, {44'b0, PID});
            end
            default: begin
               chk(fault_valid && !walk_go && !real_done, "R6 fault", {61'b0, real_done, walk_go, fault_valid}, 64'h1);
               chk(fault_code == (V_RES[i] == 2'd2 ? 2'b01 : 2'b10), "R7 code", {62'b0, fault_code},
                   (V_RES[i] == 2'd2) ? 64'h1 : 64'h2);
            end
         endcase
         chk(dar == V_DAR[i], "R8 dar", dar, V_DAR[i]);
         chk(req_ready == 1'b0, "R11 busy", {63'b0, req_ready}, 64'h0);
         @(negedge clk);
         chk(!(real_done || walk_go || fault_valid), "R10 pulse", {61'b0, real_done, walk_go, fault_valid}, 64'h0);
         chk(req_ready == 1'b1, "R11 ready", {63'b0, req_ready}, 64'h1);
         chk(real_addr == 64'h0 && walk_ea == 64'h0, "R12 idle zero", real_addr | walk_ea, 64'h0);
      end

      // R11: request held during the busy cycle is ignored
      drive(64'h0000_0000_0000_7000, 2'b00, 3'b100);
      @(negedge clk);
      chk(real_done, "R11 accept", {63'b0, real_done}, 64'h1);
      drive(64'h8000_0000_0000_0900, 2'b01, 3'b010);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!(real_done || walk_go || fault_valid), "R11 ignored", {61'b0, real_done, walk_go, fault_valid}, 64'h0);
      chk(dar == 64'h4000_0000_0000_0300, "R11 dar kept", dar, 64'h4000_0000_0000_0300);
      @(negedge clk);
      chk(!(real_done || walk_go || fault_valid), "R11 none later", {61'b0, real_done, walk_go, fault_valid}, 64'h0);

      summary();
   end
endmodule